// File: doc/BRIEF.md
# Quadrature Local-Oscillator Mixer

This block is the first stage of a digital receive chain. It takes real signed samples from a fast converter and multiplies each one by a complex local oscillator. The oscillator produces a cosine and a sine that are exactly a quarter turn apart. The cosine product forms the in-phase output and the sine product forms the quadrature output. From this point on, every later stage in the chain works on complex data. Filtering and rate reduction are left to the stages that follow.

The oscillator is a phase accumulator. It advances once per accepted sample, by a tuning word that software writes through a one-cycle write strobe. The oscillator frequency equals word × Fs / 2^PHASE_W. A retune takes effect at once, with no settling interval, no dropped samples and no reset of the phase. For example, at 100 MHz sampling a word near 0.39 × 2^32 centres a 39–40 MHz band at 0–1 MHz. The sum term then folds to about 21–22 MHz and is removed by later filtering.

The top ADDR_W bits of the phase address a quarter-wave sine table. Quadrant logic rebuilds the full sine and the full cosine from that table. Each product is rounded to OUT_W bits. The path from input to output is a fixed pipeline, and a valid flag travels alongside the data.

Top module: `iq_downmixer`

## Requirements
- R1: A synchronous reset clears the phase to 0, the tuning word to 0, out_valid to 0 and out_i/out_q to 0. The first sample after reset therefore uses phase 0.
- R2: out_valid is high after clock edge t+4 exactly when in_valid was high at edge t with reset low. It is low at all other times.
- R3: Each accepted sample advances the 32-bit phase by the tuning word modulo 2^32. Cycles with in_valid low leave the phase unchanged.
- R4: A word written with tw_we at edge t is used for every phase step made at edges after t. A sample accepted at edge t itself still steps by the previous word. A write never alters the accumulated phase.
- R5: The oscillator address is phase[31:22]. The quarter table holds T[k] = round(32767·sin(π(k+0.5)/512)) for k = 0..255.
- R6: For an address a, the sine is ±T[a[7:0]] when a[8]=0, or ±T[255−a[7:0]] when a[8]=1; it is negative when a[9]=1. The cosine is the sine at (a+256) mod 1024.
- R7: out_i = floor((x·cos + 1024)/2048) and out_q = floor((x·sin + 1024)/2048), where x is the 12-bit signed input. The value −32768 never appears.
- R8: A retune of any size between back-to-back samples drops no sample. Every accepted sample yields exactly one output.
- R9: While out_valid is low, out_i and out_q hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | IN_W (12) | Real signed input sample |
| tw_we | input | 1 | Tuning word write strobe |
| tw_word | input | PHASE_W (32) | Tuning word |
| out_valid | output | 1 | Output qualifier |
| out_i | output | OUT_W (16) | In-phase product, signed |
| out_q | output | OUT_W (16) | Quadrature product, signed |

## Verification
The bench builds the block with its default parameters: 12-bit input, 32-bit phase, 10-bit oscillator address and 16-bit output. With this build, all 1024 oscillator addresses and the extreme input codes can be reached in a short run. Tuning words of a quarter turn and a half turn land exactly on quadrant edges. Large hops alternating with small ones exercise retuning between back-to-back samples. A word near 0.39 × 2^32 reproduces the 39 MHz mixing case.

// File: rtl/iqm_pkg.sv
package iqm_pkg;
   localparam real IQM_PI = 3.14159265358979;

   // Magnitude of quarter-wave entry k out of n, sampled at bin centres
   function automatic int quarter_entry(int k, int n, int dw);
      real amp;
      real ang;
      amp = real'((1 << (dw - 1)) - 1);
      ang = IQM_PI * (real'(k) + 0.5) / (2.0 * real'(n));
      return $rtoi(amp * $sin(ang) + 0.5);
   endfunction
endpackage

// File: rtl/iqm_phase_acc.sv
module iqm_phase_acc #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic              we,
   input  logic [PHASE_W-1:0] word,
   output logic [ADDR_W-1:0] addr
);
   logic [PHASE_W-1:0] acc_q;
   logic [PHASE_W-1:0] inc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         inc_q <= '0;
      end else begin
         if (adv) acc_q <= acc_q + inc_q;
         if (we)  inc_q <= word;
      end
   end

   assign addr = acc_q[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/iqm_sincos.sv
module iqm_sincos #(
   parameter int ADDR_W = 10,
   parameter int LO_W   = 16
) (
   input  logic                   clk,
   input  logic [ADDR_W-1:0]      addr,
   output logic signed [LO_W-1:0] sin_o,
   output logic signed [LO_W-1:0] cos_o
);
   localparam int IW = ADDR_W - 2;
   localparam int N  = 1 << IW;

   logic [LO_W-1:0] rom [N];

   for (genvar k = 0; k < N; k++) begin : g_rom
      localparam int V = iqm_pkg::quarter_entry(k, N, LO_W);
      assign rom[k] = V[LO_W-1:0];
   end

   logic [ADDR_W-1:0] addr_c;
   logic [IW-1:0]     idx_s, idx_c;
   logic signed [LO_W-1:0] mag_s, mag_c;
   logic              neg_s, neg_c;

   always_comb begin
      addr_c = addr + ADDR_W'(N);
      idx_s  = addr[IW] ? ~addr[IW-1:0] : addr[IW-1:0];
      idx_c  = addr_c[IW] ? ~addr_c[IW-1:0] : addr_c[IW-1:0];
   end

   always_ff @(posedge clk) begin
      mag_s <= rom[idx_s];
      mag_c <= rom[idx_c];
      neg_s <= addr[ADDR_W-1];
      neg_c <= addr_c[ADDR_W-1];
   end

   always_ff @(posedge clk) begin
      sin_o <= neg_s ? -mag_s : mag_s;
      cos_o <= neg_c ? -mag_c : mag_c;
   end
endmodule

// File: rtl/iqm_mult_round.sv
module iqm_mult_round #(
   parameter int IN_W  = 12,
   parameter int LO_W  = 16,
   parameter int OUT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    v_in,
   input  logic signed [IN_W-1:0]  x,
   input  logic signed [LO_W-1:0]  lo_c,
   input  logic signed [LO_W-1:0]  lo_s,
   output logic                    v_out,
   output logic signed [OUT_W-1:0] y_i,
   output logic signed [OUT_W-1:0] y_q
);
   localparam int PROD_W = IN_W + LO_W;
   localparam int SHIFT  = IN_W + LO_W - 1 - OUT_W;

   logic signed [PROD_W-1:0] p_i, p_q;
   logic                     p_v;
   logic signed [OUT_W-1:0]  r_i, r_q;

   always_ff @(posedge clk) begin
      if (rst) p_v <= 1'b0;
      else     p_v <= v_in;
      if (v_in) begin
         p_i <= x * lo_c;
         p_q <= x * lo_s;
      end
   end

   if (SHIFT > 0) begin : g_round
      logic signed [PROD_W:0] s_i, s_q;
      always_comb begin
         s_i = ((PROD_W+1)'(p_i) + (PROD_W+1)'(1 << (SHIFT - 1))) >>> SHIFT;
         s_q = ((PROD_W+1)'(p_q) + (PROD_W+1)'(1 << (SHIFT - 1))) >>> SHIFT;
         r_i = s_i[OUT_W-1:0];
         r_q = s_q[OUT_W-1:0];
      end
   end else begin : g_exact
      assign r_i = p_i[OUT_W-1:0];
      assign r_q = p_q[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_out <= 1'b0;
         y_i   <= '0;
         y_q   <= '0;
      end else begin
         v_out <= p_v;
         if (p_v) begin
            y_i <= r_i;
            y_q <= r_q;
         end
      end
   end
endmodule

// File: rtl/iq_downmixer.sv
module iq_downmixer #(
   parameter int IN_W    = 12,
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 10,
   parameter int LO_W    = 16,
   parameter int OUT_W   = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_sample,
   input  logic                    tw_we,
   input  logic [PHASE_W-1:0]      tw_word,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_i,
   output logic signed [OUT_W-1:0] out_q
);
   localparam int LUT_LAT = 2;

   if (ADDR_W < 3)                  begin : g_bad_addr  $error("ADDR_W must be at least 3");       end
   if (PHASE_W < ADDR_W)            begin : g_bad_phase $error("PHASE_W must cover ADDR_W");       end
   if (IN_W + LO_W - 1 < OUT_W)     begin : g_bad_out   $error("OUT_W exceeds product precision"); end

   logic [ADDR_W-1:0] addr;
   logic              s1_v;
   logic signed [IN_W-1:0] s1_x;
   logic [ADDR_W-1:0] s1_addr;
   logic signed [LO_W-1:0] lo_s, lo_c;
   logic              d_v [LUT_LAT];
   logic signed [IN_W-1:0] d_x [LUT_LAT];

   iqm_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
      .clk(clk), .rst(rst), .adv(in_valid), .we(tw_we), .word(tw_word), .addr(addr)
   );

   always_ff @(posedge clk) begin
      if (rst) s1_v <= 1'b0;
      else     s1_v <= in_valid;
      if (in_valid) begin
         s1_x    <= in_sample;
         s1_addr <= addr;
      end
   end

   iqm_sincos #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_lo (
      .clk(clk), .addr(s1_addr), .sin_o(lo_s), .cos_o(lo_c)
   );

   for (genvar g = 0; g < LUT_LAT; g++) begin : g_dly
      always_ff @(posedge clk) begin
         if (rst) d_v[g] <= 1'b0;
         else     d_v[g] <= (g == 0) ? s1_v : d_v[(g == 0) ? 0 : g - 1];
         d_x[g] <= (g == 0) ? s1_x : d_x[(g == 0) ? 0 : g - 1];
      end
   end

   iqm_mult_round #(.IN_W(IN_W), .LO_W(LO_W), .OUT_W(OUT_W)) u_mix (
      .clk(clk), .rst(rst), .v_in(d_v[LUT_LAT-1]), .x(d_x[LUT_LAT-1]),
      .lo_c(lo_c), .lo_s(lo_s), .v_out(out_valid), .y_i(out_i), .y_q(out_q)
   );
endmodule

// File: rtl/iqm_checkers.sv
module iqm_chk_acc #(
   parameter int PHASE_W = 32
) (
   input logic               clk,
   input logic               rst,
   input logic               adv,
   input logic               we,
   input logic [PHASE_W-1:0] word,
   input logic [PHASE_W-1:0] acc_q,
   input logic [PHASE_W-1:0] inc_q
);
   logic started = 1'b0;
   logic since1  = 1'b0;
   always_ff @(posedge clk) begin
      started <= 1'b1;
      since1  <= !rst;
   end

   p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
      since1 && $past(adv) |-> acc_q == $past(acc_q) + $past(inc_q));
   p_phase_idle_r3: assert property (@(posedge clk) disable iff (rst)
      since1 && !$past(adv) |-> acc_q == $past(acc_q));
   p_tune_load_r4: assert property (@(posedge clk) disable iff (rst)
      since1 && $past(we) |-> inc_q == $past(word));
   p_acc_reset_r1: assert property (@(posedge clk)
      started && $past(rst) |-> acc_q == '0 && inc_q == '0);
endmodule

module iqm_chk_top #(
   parameter int OUT_W = 16
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_valid,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] out_i,
   input logic signed [OUT_W-1:0] out_q
);
   logic       started = 1'b0;
   logic [2:0] since   = '0;
   always_ff @(posedge clk) begin
      started <= 1'b1;
      if (rst)              since <= '0;
      else if (since != 3'd7) since <= since + 3'd1;
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (rst)
      since >= 3'd5 |-> out_valid == $past(in_valid, 5));
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      since >= 3'd1 && !out_valid |-> $stable(out_i) && $stable(out_q));
   p_no_min_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_i != {1'b1, {(OUT_W-1){1'b0}}} && out_q != {1'b1, {(OUT_W-1){1'b0}}});
   p_out_reset_r1: assert property (@(posedge clk)
      started && $past(rst) |-> !out_valid && out_i == '0 && out_q == '0);
endmodule

bind iq_downmixer iqm_chk_top #(.OUT_W(OUT_W)) u_chk_top (
   .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
   .out_i(out_i), .out_q(out_q)
);

bind iqm_phase_acc iqm_chk_acc #(.PHASE_W(PHASE_W)) u_chk_acc (
   .clk(clk), .rst(rst), .adv(adv), .we(we), .word(word),
   .acc_q(acc_q), .inc_q(inc_q)
);

// File: tb/sim_iq_downmixer.sv
`timescale 1ns/1ps
module sim_iq_downmixer;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic signed [11:0] in_sample = '0;
   logic tw_we = 1'b0;
   logic [31:0] tw_word = '0;
   logic out_valid;
   logic signed [15:0] out_i, out_q;

   always #10 clk = ~clk;

   iq_downmixer u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .tw_we(tw_we), .tw_word(tw_word), .out_valid(out_valid),
      .out_i(out_i), .out_q(out_q)
   );

   typedef struct {
      bit    v;
      int    i;
      int    q;
      string tag;
   } exp_t;

   exp_t  pipe [5];
   int    tab [256];
   int    n_chk = 0;
   int    n_err = 0;
   int    last_i = 0, last_q = 0;
   int    n_acc = 0, n_out = 0;
   logic [31:0] macc = '0, minc = '0;
   string cur_tag = "R1";
   bit    done = 1'b0;

   function automatic int sine10(int a);
      int qd, ix, m;
      qd = (a >> 8) & 3;
      ix = a & 255;
      m  = tab[(qd & 1) ? 255 - ix : ix];
      return (qd & 2) ? -m : m;
   endfunction

   function automatic int rnd(longint p);
      return int'((p + 64'sd1024) >>> 11);
   endfunction

   task automatic check(input string tag, input int act, input int exp_v, input string what);
      n_chk++;
      if (act != exp_v) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp_v, $time);
      end
   endtask

   task automatic step(input bit r, input bit v, input int x, input bit we, input logic [31:0] w);
      int a;
      @(negedge clk);
      // compare outputs against the expectation queued five negedges ago
      check("R2", int'(out_valid), int'(pipe[4].v), "out_valid");
      if (pipe[4].v) begin
         check(pipe[4].tag, int'(out_i), pipe[4].i, "out_i");
         check(pipe[4].tag, int'(out_q), pipe[4].q, "out_q");
         last_i = pipe[4].i;
         last_q = pipe[4].q;
         if (out_valid) n_out++;
      end else begin
         check(cur_tag == "R1" ? "R1" : "R9", int'(out_i), last_i, "held out_i");
         check(cur_tag == "R1" ? "R1" : "R9", int'(out_q), last_q, "held out_q");
      end
      for (int k = 4; k > 0; k--) pipe[k] = pipe[k-1];
      rst = r; in_valid = v; in_sample = 12'(x); tw_we = we; tw_word = w;
      if (r) begin
         for (int k = 0; k < 5; k++) pipe[k].v = 1'b0;
         last_i = 0; last_q = 0; macc = '0; minc = '0; n_acc = 0; n_out = 0;
      end else begin
         pipe[0].v = v;
         pipe[0].tag = cur_tag;
         if (v) begin
            a = int'(macc[31:22]);
            pipe[0].i = rnd(longint'(x) * longint'(sine10((a + 256) & 1023)));
            pipe[0].q = rnd(longint'(x) * longint'(sine10(a)));
            macc = macc + minc;
            n_acc++;
         end
         if (we) minc = w;
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int k = 0; k < 256; k++)
         tab[k] = $rtoi(32767.0 * $sin(3.14159265358979 * (real'(k) + 0.5) / 512.0) + 0.5);
      for (int k = 0; k < 5; k++) begin pipe[k].v = 1'b0; pipe[k].i = 0; pipe[k].q = 0; pipe[k].tag = "R1"; end

      // R1: reset state, then samples at phase 0 with no tuning word written
      cur_tag = "R1";
      repeat (4) step(1, 0, 0, 0, 0);
      step(0, 1, 2047, 0, 0);
      step(0, 1, -2048, 0, 0);
      // R5: phase stays at address 0 when the word is zero
      cur_tag = "R5";
      step(0, 1, 1000, 0, 0);
      step(0, 0, 0, 0, 0);
      // R6: quarter-turn word walks through every quadrant edge
      cur_tag = "R6";
      step(0, 0, 0, 1, 32'h4000_0000);
      repeat (8) step(0, 1, 2047, 0, 0);
      step(0, 0, 0, 1, 32'h0040_0000);
      repeat (12) step(0, 1, -2048, 0, 0);
      // R4: write and sample at the same edge, old word steps that sample
      cur_tag = "R4";
      step(0, 1, 1500, 1, 32'h8000_0000);
      repeat (3) step(0, 1, 1500, 0, 0);
      step(0, 1, -700, 1, 32'h0123_4567);
      step(0, 1, -700, 0, 0);
      // R8: large hops between back-to-back samples
      cur_tag = "R8";
      for (int k = 0; k < 40; k++)
         step(0, 1, $signed(12'($urandom)), 1, (k % 2) ? 32'h0000_1000 : 32'hC000_0001);
      // R3: a 39/100 word with random input
      cur_tag = "R3";
      step(0, 0, 0, 1, 32'd1675037245);
      for (int k = 0; k < 300; k++) step(0, 1, $signed(12'($urandom)), 0, 0);
      // R7 / R9: random valid gaps, random retunes
      cur_tag = "R7";
      for (int k = 0; k < 3000; k++)
         step(0, ($urandom % 10) < 6, $signed(12'($urandom)), ($urandom % 20) == 0, $urandom);
      // R1: reset in mid-stream drops in-flight samples and clears the phase
      cur_tag = "R1";
      step(0, 1, 900, 1, 32'h1111_1111);
      step(0, 1, 900, 0, 0);
      step(1, 1, 900, 0, 0);
      step(0, 1, 2047, 0, 0);
      step(0, 1, 2047, 0, 0);
      cur_tag = "R7";
      for (int k = 0; k < 1500; k++)
         step(0, ($urandom % 10) < 8, $signed(12'($urandom)), ($urandom % 30) == 0, $urandom);
      repeat (8) step(0, 0, 0, 0, 0);
      // R8: every sample accepted since the last reset came out once
      check("R8", n_out, n_acc, "output count");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule